// File: doc/BRIEF.md
# Reference-Clock Frequency Lock Monitor

This block judges whether a synthesized high-speed clock runs at the frequency its reference clock asks for. The fast feedback clock is divided down to the reference rate, by 16 or by 64 as a configuration pin selects. Divided feedback ticks are then counted across a measurement window of a fixed number of reference cycles. When the number of ticks seen in one window is within a small tolerance of the window length, that window counts as good. The lock flag goes high after two good windows in a row and drops as soon as one window misses.

The divider and its tick counter run in the feedback clock domain. The count crosses to the reference domain as a Gray code. Each measurement is the difference between two samples of that count taken one window apart, so the first window after a reset or a restart only sets the baseline. Changing the divide setting, or a reset, clears the flag and starts a fresh measurement. The control and status pins are plain levels with no handshake.

Top module: `refclk_lock_monitor`

## Requirements
- R1: `lock` is 0 while `ref_rst_n` is low, it clears as soon as reset asserts, and it stays 0 for at least one full window after reset is released.
- R2: `ratio_sel` = 0 divides `fb_clk` by 16 (`DIV_LO`) and `ratio_sel` = 1 divides it by 64 (`DIV_HI`). A feedback clock at exactly that multiple of the reference leads to `lock` = 1.
- R3: A window is 2^`WIN_LOG2` reference cycles long. `lock` changes only on the edge that closes a window or on a restart edge. The Gray-coded feedback count changes by at most one bit per feedback edge.
- R4: A window is good when the number of divided feedback ticks it holds differs from 2^`WIN_LOG2` by no more than `TOL`. Otherwise it is bad. This includes a feedback clock that runs at the wrong multiple.
- R5: The first window after a reset or a restart is a baseline and is not judged. `lock` rises only at the close of the second good window in a row.
- R6: A single bad window sets `lock` to 0 on the edge that closes it.
- R7: A change of `ratio_sel` sets `lock` to 0 on the next `ref_clk` edge and restarts the window. This takes precedence over a window evaluation that falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the measurement window is counted in this domain |
| ref_rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk | input | 1 | Synthesized high-speed clock to be measured |
| ratio_sel | input | 1 | Divide select: 0 for 16, 1 for 64 |
| lock | output | 1 | High while the feedback frequency agrees with the reference |

## Verification
A restart caused by a change of `ratio_sel` and the evaluation of a good window can land on the same `ref_clk` edge. The bench provokes this after a lock has been regained in divide-by-64 mode. It counts reference cycles from a known restart and changes `ratio_sel` in the cycle just before a window boundary. Lock must read 0 right after that edge. If the evaluation had won instead, lock would have stayed 1.

// File: rtl/lockmon_pkg.sv
`timescale 1ns/1fs
package lockmon_pkg;
  typedef enum logic {
    RATIO_LO = 1'b0,
    RATIO_HI = 1'b1
  } ratio_e;

  // Good windows in a row needed before the flag is raised.
  localparam int GOOD_RUN = 2;
endpackage

// File: rtl/lockmon_sync.sv
`timescale 1ns/1fs
module lockmon_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lockmon_rst_sync.sv
`timescale 1ns/1fs
module lockmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/lockmon_fb_count.sv
`timescale 1ns/1fs
module lockmon_fb_count
  import lockmon_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 64,
  parameter int CNT_W  = 17
) (
  input  logic             fb_clk,
  input  logic             fb_rst_n,
  input  ratio_e           ratio_mode,
  output logic             tick,
  output logic [CNT_W-1:0] gray_q
);
  localparam int DIV_W = $clog2(DIV_HI);
  localparam logic [DIV_W-1:0] LIM_LO = DIV_W'(DIV_LO - 1);
  localparam logic [DIV_W-1:0] LIM_HI = DIV_W'(DIV_HI - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] lim;
  logic             wrap;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign lim    = (ratio_mode == RATIO_HI) ? LIM_HI : LIM_LO;
  // >= lets a switch from the long to the short ratio wrap at once
  assign wrap   = (div_cnt >= lim);
  assign bin_nx = wrap ? (bin_q + CNT_W'(1)) : bin_q;

  always_ff @(posedge fb_clk or negedge fb_rst_n) begin
    if (!fb_rst_n) begin
      div_cnt <= '0;
      tick    <= 1'b0;
      bin_q   <= '0;
      gray_q  <= '0;
    end else begin
      div_cnt <= wrap ? '0 : (div_cnt + DIV_W'(1));
      tick    <= wrap;
      bin_q   <= bin_nx;
      gray_q  <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/lockmon_window.sv
`timescale 1ns/1fs
module lockmon_window
  import lockmon_pkg::*;
#(
  parameter int WIN_LOG2 = 14,
  parameter int TOL      = 8,
  parameter int CNT_W    = 17
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] fb_gray,
  output logic             lock,
  output logic             win_last,
  output logic             skip_q,
  output logic             good_q
);
  localparam logic [CNT_W-1:0] WIN_SPAN = CNT_W'(1) << WIN_LOG2;
  localparam logic [CNT_W-1:0] TOL_V    = CNT_W'(TOL);

  logic [WIN_LOG2-1:0] win_cnt;
  logic [CNT_W-1:0]    fb_bin;
  logic [CNT_W-1:0]    prev_q;
  logic [CNT_W-1:0]    delta;
  logic [CNT_W-1:0]    err;
  logic [CNT_W-1:0]    mag;
  logic                in_tol;

  for (genvar i = 0; i < CNT_W; i++) begin : g_gray2bin
    assign fb_bin[i] = ^fb_gray[CNT_W-1:i];
  end

  assign win_last = &win_cnt;
  assign delta    = fb_bin - prev_q;
  assign err      = delta - WIN_SPAN;
  assign mag      = err[CNT_W-1] ? (-err) : err;
  assign in_tol   = (mag <= TOL_V);

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      win_cnt <= '0;
      prev_q  <= '0;
      skip_q  <= 1'b1;
      good_q  <= 1'b0;
      lock    <= 1'b0;
    end else if (restart) begin
      win_cnt <= '0;
      skip_q  <= 1'b1;
      good_q  <= 1'b0;
      lock    <= 1'b0;
    end else begin
      win_cnt <= win_cnt + WIN_LOG2'(1);
      if (win_last) begin
        prev_q <= fb_bin;
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (in_tol) begin
          good_q <= 1'b1;
          if (good_q) lock <= 1'b1;
        end else begin
          good_q <= 1'b0;
          lock   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/refclk_lock_monitor.sv
`timescale 1ns/1fs
module refclk_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int WIN_LOG2    = 14,
  parameter int TOL         = 8,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic fb_clk,
  input  logic ratio_sel,
  output logic lock
);
  localparam int CNT_W = WIN_LOG2 + 3;

  ratio_e           ratio_q;
  ratio_e           ratio_fb;
  logic             ratio_fb_raw;
  logic             restart;
  logic             fb_rst_n;
  logic             fb_tick;
  logic [CNT_W-1:0] fb_gray;
  logic [CNT_W-1:0] gray_ref;
  logic             win_last;
  logic             skip_q;
  logic             good_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ratio_q <= RATIO_LO;
    else            ratio_q <= ratio_e'(ratio_sel);
  end

  assign restart = (ratio_e'(ratio_sel) != ratio_q);

  lockmon_rst_sync #(.STAGES(SYNC_STAGES)) u_fb_rst (
    .clk    (fb_clk),
    .arst_n (ref_rst_n),
    .rst_n  (fb_rst_n)
  );

  lockmon_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ratio_sync (
    .clk   (fb_clk),
    .rst_n (fb_rst_n),
    .d     (ratio_q),
    .q     (ratio_fb_raw)
  );

  assign ratio_fb = ratio_e'(ratio_fb_raw);

  lockmon_fb_count #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .CNT_W(CNT_W)) u_fb (
    .fb_clk     (fb_clk),
    .fb_rst_n   (fb_rst_n),
    .ratio_mode (ratio_fb),
    .tick       (fb_tick),
    .gray_q     (fb_gray)
  );

  lockmon_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .d     (fb_gray),
    .q     (gray_ref)
  );

  lockmon_window #(.WIN_LOG2(WIN_LOG2), .TOL(TOL), .CNT_W(CNT_W)) u_win (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .restart   (restart),
    .fb_gray   (gray_ref),
    .lock      (lock),
    .win_last  (win_last),
    .skip_q    (skip_q),
    .good_q    (good_q)
  );
endmodule

// File: rtl/lockmon_chk.sv
`timescale 1ns/1fs
module lockmon_chk #(
  parameter int CNT_W = 17
) (
  input logic             ref_clk,
  input logic             ref_rst_n,
  input logic             fb_clk,
  input logic             fb_rst_n,
  input logic             restart,
  input logic             lock,
  input logic             win_last,
  input logic             skip_q,
  input logic             good_q,
  input logic             fb_tick,
  input logic [CNT_W-1:0] fb_gray
);
  // R1
  lock_rst_chk: assert property (@(posedge ref_clk) !ref_rst_n |-> !lock);

  // R3
  lock_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(win_last || restart) |=> $stable(lock));

  // R7
  restart_clr_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    restart |=> !lock);

  // R5
  lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(lock) |-> ($past(win_last) && $past(good_q) && !$past(skip_q)));

  // R5
  baseline_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    skip_q |-> !lock);

  // R3
  gray_step_chk: assert property (@(posedge fb_clk) disable iff (!fb_rst_n)
    $countones(fb_gray ^ $past(fb_gray)) <= 1);

  // R2
  tick_gap_chk: assert property (@(posedge fb_clk) disable iff (!fb_rst_n)
    fb_tick |=> !fb_tick);
endmodule

bind refclk_lock_monitor lockmon_chk #(.CNT_W(CNT_W)) u_chk (
  .ref_clk   (ref_clk),
  .ref_rst_n (ref_rst_n),
  .fb_clk    (fb_clk),
  .fb_rst_n  (fb_rst_n),
  .restart   (restart),
  .lock      (lock),
  .win_last  (win_last),
  .skip_q    (skip_q),
  .good_q    (good_q),
  .fb_tick   (fb_tick),
  .fb_gray   (fb_gray)
);

// File: tb/sim_refclk_lock_monitor.sv
`timescale 1ns/1fs
module sim_refclk_lock_monitor;
  localparam int  WL   = 10;
  localparam int  W    = 1 << WL;
  localparam int  WD   = 200000;
  localparam real H16  = 10.0 / 32.0;
  localparam real H64  = 10.0 / 128.0;

  logic ref_clk   = 1'b0;
  logic fb_clk    = 1'b0;
  logic ref_rst_n = 1'b0;
  logic ratio_sel = 1'b0;
  logic lock;
  real  fb_half   = H16;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  refclk_lock_monitor #(.WIN_LOG2(WL), .TOL(4)) u0 (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .fb_clk    (fb_clk),
    .ratio_sel (ratio_sel),
    .lock      (lock)
  );

  always #5 ref_clk = ~ref_clk;
  always #(fb_half) fb_clk = ~fb_clk;

  task automatic tick_n(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(input string tag, input logic exp);
    total++;
    if (lock !== exp) begin
      bad++;
      $display("FAIL %s: lock=%0b expected=%0b at %0t", tag, lock, exp, $time);
    end
  endtask

  // R1: flag low in reset and through the first window afterwards
  task automatic t_reset_state();
    tick_n(10);
    chk("R1 reset state", 1'b0);
    ref_rst_n = 1'b1;
    tick_n(W - 2);
    chk("R1 low in first window", 1'b0);
  endtask

  // R5 / R2: baseline plus two good windows before lock
  task automatic t_first_lock();
    tick_n(2560 - (W - 2));
    chk("R5 one good window not enough", 1'b0);
    tick_n(W);
    chk("R2 lock at divide 16", 1'b1);
  endtask

  // R6: feedback 3 percent fast or slow drops the flag
  task automatic t_offset_loss(input real scale, input string tag);
    fb_half = H16 / scale;
    tick_n(2 * W + 4);
    chk(tag, 1'b0);
    fb_half = H16;
    tick_n(3 * W + 4);
    chk("R6 recovery after nominal", 1'b1);
  endtask

  // R4: small offset stays inside tolerance
  task automatic t_small_offset();
    fb_half = H16 / 1.002;
    for (int i = 0; i < 3; i++) begin
      tick_n(W);
      chk("R4 small offset keeps lock", 1'b1);
    end
  endtask

  // R4: offset just past tolerance
  task automatic t_near_limit();
    fb_half = H16 / 1.008;
    tick_n(2 * W + 4);
    chk("R4 offset beyond tolerance", 1'b0);
    fb_half = H16;
    tick_n(3 * W + 4);
    chk("R4 relock at nominal", 1'b1);
  endtask

  // R7, R5, R2, R3, R6 in divide-64 mode with exact edge accounting
  task automatic t_ratio64();
    ratio_sel = 1'b1;
    fb_half   = H64;
    tick_n(1);                       // after restart edge (edge 0)
    chk("R7 ratio change clears lock", 1'b0);
    tick_n(2560);
    chk("R5 baseline after restart", 1'b0);
    tick_n(1024);                    // after edge 3584
    chk("R2 lock at divide 64", 1'b1);
    fb_half = H64 / 1.03;
    tick_n(510);                     // after edge 4094
    chk("R3 no change inside window", 1'b1);
    tick_n(3);                       // after edge 4097
    chk("R6 drop at window close", 1'b0);
    fb_half = H64;
    tick_n(2103);                    // after edge 6200
    chk("R4 relock at divide 64", 1'b1);
    tick_n(967);                     // after edge 7167
    ratio_sel = 1'b0;                // restart lands on boundary 7168
    fb_half   = H16;
    tick_n(1);
    chk("R7 restart wins over evaluation", 1'b0);
    tick_n(2560);
    chk("R5 baseline after second restart", 1'b0);
    tick_n(1024);
    chk("R2 lock back at divide 16", 1'b1);
  endtask

  // R4: feedback four times too fast for the selected ratio
  task automatic t_mismatch();
    fb_half = H64;
    tick_n(2 * W + 4);
    chk("R4 wrong multiple loses lock", 1'b0);
    fb_half = H16;
    tick_n(3 * W + 4);
    chk("R4 relock after mismatch", 1'b1);
  endtask

  // R1: reset while locked
  task automatic t_reset_midlock();
    @(negedge ref_clk);
    ref_rst_n = 1'b0;
    #1;
    chk("R1 reset clears lock", 1'b0);
    tick_n(5);
    ref_rst_n = 1'b1;
    tick_n(W);
    chk("R1 low after reset release", 1'b0);
  endtask

  initial begin
    repeat (WD) @(posedge ref_clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run=%0d expected=finished", WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_first_lock();
    t_offset_loss(1.03, "R6 fast feedback loses lock");
    t_small_offset();
    t_near_limit();
    t_offset_loss(0.97, "R6 slow feedback loses lock");
    t_ratio64();
    t_mismatch();
    t_reset_midlock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule